// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block sits in the decode stage of a 64-bit RISC-V core. It looks at two consecutive 32-bit instruction words, the earlier one ("head") and the later one ("tail"). It is purely combinational and reports whether the two form one of a fixed set of idioms that later stages can execute as a single macro-operation. The idioms are:

- building a wide constant
- an indexed load
- a shift-then-add
- a PC-relative call
- a multiply that yields both halves
- a quotient together with its remainder
- zero-extension done with two shifts
- absolute or PC-relative loads
- load and store pairs at adjacent doublewords

A match depends on more than the two opcodes. Destination and source registers must line up across the pair, shift amounts must fall in the allowed sets, and memory offsets must be exactly one stride apart.

On a match the block reports four things: a fusion flag, a 4-bit kind code, the destination register of the merged operation and, where the idiom has one, the merged immediate. For the load pair and the store pair the match itself is the product; no merged write-back is formed.

Top module: `fuse_pair_detect`

## Requirements
- R1: LUI rd,U followed by ADDI rd,rd,I (tail source equals head rd) gives kind 1, dest rd, imm = (U<<12) + sign-extended I, with a negative I lowering the upper part.
- R2: ADD rd,a,b followed by LD rd,0(rd) gives kind 2, dest rd, imm 0; any non-zero load offset does not fuse.
- R3: SLLI rd,a,s with s in 1..3 followed by ADD rd,rd,b gives kind 3, dest rd, imm s; any other shift amount does not fuse.
- R4: AUIPC t,U followed by JALR x1,I(t) gives kind 4, dest 1, imm = (U<<12) + sign-extended I; a link register other than x1 does not fuse.
- R5: MULH, MULHSU or MULHU followed by MUL with the same two sources, in the same order, gives kind 5 with the dest of the tail; the pair does not fuse if the head rd equals either source.
- R6: DIV or DIVU followed by REM or REMU with the same sources and the same signedness (funct3 bit 0 equal) gives kind 6 with the dest of the tail; a head rd equal to a source, or mixed signedness, does not fuse.
- R7: SLLI rd,a,32 followed by SRLI rd,rd,k with k in 29..32 gives kind 7, dest rd, imm k; any other k does not fuse.
- R8: LD d1,o(b) followed by LD d2,o+8(b) gives kind 8, dest d1, imm = sign-extended o; the pair does not fuse if d1 equals b or if the offsets are not exactly 8 apart.
- R9: SD x,o(b) followed by SD y,o+8(b) gives kind 9, dest 0, imm = sign-extended o.
- R10: LUI rd,U or AUIPC rd,U followed by LD rd,I(rd) gives kind 10 (LUI) or kind 11 (AUIPC), dest rd, imm = (U<<12) + sign-extended I; a different load destination does not fuse.
- R11: When no idiom matches, the fuse flag, kind, dest and imm are all zero.
- R12: At most one idiom matches any pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| head_i | input | 32 | Earlier instruction word of the pair |
| tail_i | input | 32 | Later instruction word of the pair |
| fuse_o | output | 1 | The pair forms a fusible idiom |
| kind_o | output | 4 | Idiom code (0 none, 1..11 as in the requirements) |
| dest_o | output | 5 | Destination register of the merged operation |
| imm_o | output | 32 | Merged immediate, offset or shift amount |

## Verification
The bench aims at register-hazard corners. One case is a multiply or divide head that overwrites one of its own sources; a detector that ignored this would fuse a pair whose tail reads the clobbered value. Another is a load pair whose first destination is the base; a careless detector would report a pair whose second address is already gone. It also covers:

- shift amounts just outside the allowed sets
- load offsets of +16 instead of +8
- mixed-signedness divide/remainder pairs
- swapped source operands

Negative low immediates test sign handling in the merged constant: a wrong design would return a value 4096 too high.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

   typedef enum logic [3:0] {
      FK_NONE     = 4'd0,
      FK_WIDE_IMM = 4'd1,
      FK_IDX_LD   = 4'd2,
      FK_SHADD    = 4'd3,
      FK_PC_CALL  = 4'd4,
      FK_MUL_WIDE = 4'd5,
      FK_DIVREM   = 4'd6,
      FK_ZEXT     = 4'd7,
      FK_LD_PAIR  = 4'd8,
      FK_ST_PAIR  = 4'd9,
      FK_ABS_LD   = 4'd10,
      FK_PCREL_LD = 4'd11
   } fuse_kind_e;

   localparam int NUM_KINDS = 12;

   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;

   localparam logic [6:0] F7_BASE    = 7'b0000000;
   localparam logic [6:0] F7_MULDIV  = 7'b0000001;
   localparam logic [2:0] F3_DWORD   = 3'b011;

   typedef struct packed {
      logic [6:0]  opc;
      logic [4:0]  rd;
      logic [4:0]  rs1;
      logic [4:0]  rs2;
      logic [2:0]  f3;
      logic [6:0]  f7;
      logic [5:0]  f6;
      logic [5:0]  shamt;
      logic [11:0] imm_i;
      logic [11:0] imm_s;
      logic [19:0] imm_u;
   } insn_f_t;

endpackage

// File: rtl/fuse_field_split.sv
module fuse_field_split
   import fuse_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic [ILEN-1:0] word_i,
   output insn_f_t         f_o
);

   if (ILEN != 32) begin : g_bad_ilen
      $error("fuse_field_split: ILEN must be 32");
   end

   assign f_o.opc   = word_i[6:0];
   assign f_o.rd    = word_i[11:7];
   assign f_o.f3    = word_i[14:12];
   assign f_o.rs1   = word_i[19:15];
   assign f_o.rs2   = word_i[24:20];
   assign f_o.f7    = word_i[31:25];
   assign f_o.f6    = word_i[31:26];
   assign f_o.shamt = word_i[25:20];
   assign f_o.imm_i = word_i[31:20];
   assign f_o.imm_s = {word_i[31:25], word_i[11:7]};
   assign f_o.imm_u = word_i[31:12];

endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
   import fuse_pkg::*;
#(
   parameter int PAIR_STRIDE = 8,
   parameter bit EN_MEM_PAIR = 1'b1
) (
   input  insn_f_t              h_i,
   input  insn_f_t              t_i,
   output logic [NUM_KINDS-1:0] hit_o
);

   localparam int OFFW = 13;

   if (PAIR_STRIDE <= 0 || PAIR_STRIDE >= 2048) begin : g_bad_stride
      $error("fuse_pair_match: PAIR_STRIDE out of range");
   end

   logic h_lui, h_auipc, h_addi, h_slli, h_add, h_mulh, h_div, h_ld, h_sd;
   logic t_addi, t_slli, t_srli, t_add, t_mul, t_rem, t_ld, t_sd, t_jalr;
   logic chain_rd, mul_src_same, head_clobbers;
   logic ld_pair_hit, st_pair_hit;

   always_comb begin
      h_lui   = (h_i.opc == OPC_LUI);
      h_auipc = (h_i.opc == OPC_AUIPC);
      h_addi  = (h_i.opc == OPC_OPIMM) && (h_i.f3 == 3'b000);
      h_slli  = (h_i.opc == OPC_OPIMM) && (h_i.f3 == 3'b001) && (h_i.f6 == 6'd0);
      h_add   = (h_i.opc == OPC_OP) && (h_i.f7 == F7_BASE) && (h_i.f3 == 3'b000);
      h_mulh  = (h_i.opc == OPC_OP) && (h_i.f7 == F7_MULDIV) &&
                (h_i.f3 != 3'b000) && (h_i.f3[2] == 1'b0);
      h_div   = (h_i.opc == OPC_OP) && (h_i.f7 == F7_MULDIV) && (h_i.f3[2:1] == 2'b10);
      h_ld    = (h_i.opc == OPC_LOAD) && (h_i.f3 == F3_DWORD);
      h_sd    = (h_i.opc == OPC_STORE) && (h_i.f3 == F3_DWORD);

      t_addi  = (t_i.opc == OPC_OPIMM) && (t_i.f3 == 3'b000);
      t_slli  = (t_i.opc == OPC_OPIMM) && (t_i.f3 == 3'b001) && (t_i.f6 == 6'd0);
      t_srli  = (t_i.opc == OPC_OPIMM) && (t_i.f3 == 3'b101) && (t_i.f6 == 6'd0);
      t_add   = (t_i.opc == OPC_OP) && (t_i.f7 == F7_BASE) && (t_i.f3 == 3'b000);
      t_mul   = (t_i.opc == OPC_OP) && (t_i.f7 == F7_MULDIV) && (t_i.f3 == 3'b000);
      t_rem   = (t_i.opc == OPC_OP) && (t_i.f7 == F7_MULDIV) && (t_i.f3[2:1] == 2'b11);
      t_ld    = (t_i.opc == OPC_LOAD) && (t_i.f3 == F3_DWORD);
      t_sd    = (t_i.opc == OPC_STORE) && (t_i.f3 == F3_DWORD);
      t_jalr  = (t_i.opc == OPC_JALR) && (t_i.f3 == 3'b000);

      // tail both reads and rewrites the head destination
      chain_rd      = (t_i.rs1 == h_i.rd) && (t_i.rd == h_i.rd);
      mul_src_same  = (t_i.rs1 == h_i.rs1) && (t_i.rs2 == h_i.rs2);
      head_clobbers = (h_i.rd == h_i.rs1) || (h_i.rd == h_i.rs2);
   end

   if (EN_MEM_PAIR) begin : g_mem_pair
      logic signed [OFFW-1:0] ld_next, st_next;
      assign ld_next = OFFW'(signed'(h_i.imm_i)) + OFFW'(PAIR_STRIDE);
      assign st_next = OFFW'(signed'(h_i.imm_s)) + OFFW'(PAIR_STRIDE);
      assign ld_pair_hit = h_ld && t_ld && (t_i.rs1 == h_i.rs1) &&
                           (h_i.rd != h_i.rs1) &&
                           (OFFW'(signed'(t_i.imm_i)) == ld_next);
      assign st_pair_hit = h_sd && t_sd && (t_i.rs1 == h_i.rs1) &&
                           (OFFW'(signed'(t_i.imm_s)) == st_next);
   end else begin : g_no_mem_pair
      assign ld_pair_hit = 1'b0;
      assign st_pair_hit = 1'b0;
   end

   always_comb begin
      hit_o = '0;
      hit_o[FK_WIDE_IMM] = h_lui && t_addi && chain_rd;
      hit_o[FK_IDX_LD]   = h_add && t_ld && chain_rd && (t_i.imm_i == 12'd0);
      hit_o[FK_SHADD]    = h_slli && t_add && chain_rd &&
                           (h_i.shamt >= 6'd1) && (h_i.shamt <= 6'd3);
      hit_o[FK_PC_CALL]  = h_auipc && t_jalr && (t_i.rs1 == h_i.rd) && (t_i.rd == 5'd1);
      hit_o[FK_MUL_WIDE] = h_mulh && t_mul && mul_src_same && !head_clobbers;
      hit_o[FK_DIVREM]   = h_div && t_rem && mul_src_same && !head_clobbers &&
                           (h_i.f3[0] == t_i.f3[0]);
      hit_o[FK_ZEXT]     = h_slli && t_srli && chain_rd && (h_i.shamt == 6'd32) &&
                           (t_i.shamt >= 6'd29) && (t_i.shamt <= 6'd32);
      hit_o[FK_LD_PAIR]  = ld_pair_hit;
      hit_o[FK_ST_PAIR]  = st_pair_hit;
      hit_o[FK_ABS_LD]   = h_lui && t_ld && chain_rd;
      hit_o[FK_PCREL_LD] = h_auipc && t_ld && chain_rd;
   end

   // R12: idioms are disjoint
   always_comb begin
      a_r12_single_idiom: assert ($onehot0(hit_o))
         else $error("more than one idiom matched");
   end

endmodule

// File: rtl/fuse_out_pack.sv
module fuse_out_pack
   import fuse_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [NUM_KINDS-1:0] hit_i,
   input  insn_f_t              h_i,
   input  insn_f_t              t_i,
   output logic                 fuse_o,
   output logic [3:0]           kind_o,
   output logic [4:0]           dest_o,
   output logic [IMM_W-1:0]     imm_o
);

   if (IMM_W != 32) begin : g_bad_immw
      $error("fuse_out_pack: IMM_W must be 32");
   end

   fuse_kind_e       kind;
   logic [IMM_W-1:0] wide_c;

   assign wide_c = {h_i.imm_u, 12'd0} + IMM_W'(signed'(t_i.imm_i));

   always_comb begin
      kind = FK_NONE;
      for (int k = 1; k < NUM_KINDS; k++) begin
         if (hit_i[k]) kind = fuse_kind_e'(4'(k));
      end
   end

   always_comb begin
      dest_o = '0;
      imm_o  = '0;
      unique case (kind)
         FK_WIDE_IMM, FK_ABS_LD, FK_PCREL_LD: begin
            dest_o = h_i.rd;
            imm_o  = wide_c;
         end
         FK_PC_CALL: begin
            dest_o = t_i.rd;
            imm_o  = wide_c;
         end
         FK_IDX_LD:  dest_o = h_i.rd;
         FK_SHADD: begin
            dest_o = h_i.rd;
            imm_o  = IMM_W'(h_i.shamt);
         end
         FK_ZEXT: begin
            dest_o = h_i.rd;
            imm_o  = IMM_W'(t_i.shamt);
         end
         FK_MUL_WIDE, FK_DIVREM: dest_o = t_i.rd;
         FK_LD_PAIR: begin
            dest_o = h_i.rd;
            imm_o  = IMM_W'(signed'(h_i.imm_i));
         end
         FK_ST_PAIR: imm_o = IMM_W'(signed'(h_i.imm_s));
         default: ;
      endcase
   end

   assign fuse_o = (kind != FK_NONE);
   assign kind_o = kind;

   always_comb begin
      // R11: silent outputs when nothing fused
      a_r11_quiet_when_none: assert (fuse_o || (dest_o == '0 && imm_o == '0))
         else $error("outputs active without a match");
      // R3: merged shift amount within the scaled-index set
      a_r3_shift_in_set: assert (kind != FK_SHADD || (imm_o >= 1 && imm_o <= 3))
         else $error("shift-add reported with bad shift");
      // R7: right shift within the zero-extension set
      a_r7_zext_range: assert (kind != FK_ZEXT || (imm_o >= 29 && imm_o <= 32))
         else $error("zero-extend reported with bad shift");
      // R4: call writes the link register
      a_r4_call_link: assert (kind != FK_PC_CALL || dest_o == 5'd1)
         else $error("call fused without x1 link");
      // R9: store pair writes no register
      a_r9_store_no_dest: assert (kind != FK_ST_PAIR || dest_o == 5'd0)
         else $error("store pair reported a destination");
   end

endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
   import fuse_pkg::*;
#(
   parameter int ILEN        = 32,
   parameter int REG_AW      = 5,
   parameter int IMM_W       = 32,
   parameter int PAIR_STRIDE = 8,
   parameter bit EN_MEM_PAIR = 1'b1
) (
   input  logic [ILEN-1:0]   head_i,
   input  logic [ILEN-1:0]   tail_i,
   output logic              fuse_o,
   output logic [3:0]        kind_o,
   output logic [REG_AW-1:0] dest_o,
   output logic [IMM_W-1:0]  imm_o
);

   localparam int SLOTS = 2;

   if (REG_AW != 5) begin : g_bad_regaw
      $error("fuse_pair_detect: REG_AW must be 5");
   end

   logic [ILEN-1:0]      words [SLOTS];
   insn_f_t              fields [SLOTS];
   logic [NUM_KINDS-1:0] hit;

   assign words[0] = head_i;
   assign words[1] = tail_i;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      fuse_field_split #(.ILEN(ILEN)) u_split (
         .word_i (words[s]),
         .f_o    (fields[s])
      );
   end

   fuse_pair_match #(
      .PAIR_STRIDE (PAIR_STRIDE),
      .EN_MEM_PAIR (EN_MEM_PAIR)
   ) u_match (
      .h_i   (fields[0]),
      .t_i   (fields[1]),
      .hit_o (hit)
   );

   fuse_out_pack #(.IMM_W(IMM_W)) u_pack (
      .hit_i  (hit),
      .h_i    (fields[0]),
      .t_i    (fields[1]),
      .fuse_o (fuse_o),
      .kind_o (kind_o),
      .dest_o (dest_o),
      .imm_o  (imm_o)
   );

endmodule

// File: tb/sim_fuse_pair_detect.sv
module sim_fuse_pair_detect;

   typedef struct {
      logic        fuse;
      logic [3:0]  kind;
      logic [4:0]  dest;
      logic [31:0] imm;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] head = '0, tail = '0;
   logic        fuse;
   logic [3:0]  kind;
   logic [4:0]  dest;
   logic [31:0] imm;
   exp_t        sb_q [$];
   int          n_vec = 0, n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   fuse_pair_detect u0 (
      .head_i (head), .tail_i (tail),
      .fuse_o (fuse), .kind_o (kind), .dest_o (dest), .imm_o (imm)
   );

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] b,
         input logic [4:0] a, input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
      return {f7, b, a, f3, d, op};
   endfunction
   function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] a,
         input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
      return {im, a, f3, d, op};
   endfunction
   function automatic logic [31:0] lui(input logic [4:0] d, input logic [19:0] u);
      return {u, d, 7'b0110111};
   endfunction
   function automatic logic [31:0] auipc(input logic [4:0] d, input logic [19:0] u);
      return {u, d, 7'b0010111};
   endfunction
   function automatic logic [31:0] addi(input logic [4:0] d, input logic [4:0] a, input logic [11:0] im);
      return enc_i(im, a, 3'b000, d, 7'b0010011);
   endfunction
   function automatic logic [31:0] slli(input logic [4:0] d, input logic [4:0] a, input logic [5:0] sh);
      return enc_i({6'd0, sh}, a, 3'b001, d, 7'b0010011);
   endfunction
   function automatic logic [31:0] srli(input logic [4:0] d, input logic [4:0] a, input logic [5:0] sh);
      return enc_i({6'd0, sh}, a, 3'b101, d, 7'b0010011);
   endfunction
   function automatic logic [31:0] add(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
      return enc_r(7'd0, b, a, 3'b000, d, 7'b0110011);
   endfunction
   function automatic logic [31:0] md(input logic [2:0] f3, input logic [4:0] d,
         input logic [4:0] a, input logic [4:0] b);
      return enc_r(7'd1, b, a, f3, d, 7'b0110011);
   endfunction
   function automatic logic [31:0] ld(input logic [4:0] d, input logic [4:0] a, input logic [11:0] im);
      return enc_i(im, a, 3'b011, d, 7'b0000011);
   endfunction
   function automatic logic [31:0] jalr(input logic [4:0] d, input logic [4:0] a, input logic [11:0] im);
      return enc_i(im, a, 3'b000, d, 7'b1100111);
   endfunction
   function automatic logic [31:0] sd(input logic [4:0] b, input logic [4:0] a, input logic [11:0] im);
      return {im[11:5], b, a, 3'b011, im[4:0], 7'b0100011};
   endfunction

   task automatic apply(input logic [31:0] h, input logic [31:0] t, input logic f,
         input logic [3:0] k, input logic [4:0] d, input logic [31:0] i, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      head = h;
      tail = t;
      e.fuse = f; e.kind = k; e.dest = d; e.imm = i; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic nofuse(input logic [31:0] h, input logic [31:0] t, input string tag);
      apply(h, t, 1'b0, 4'd0, 5'd0, 32'd0, tag);
   endtask

   // monitor: compare half a cycle after each vector is driven
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_vec++;
         if (fuse !== e.fuse || kind !== e.kind || dest !== e.dest || imm !== e.imm) begin
            n_bad++;
            $display("FAIL %s: got fuse=%0b kind=%0d dest=%0d imm=%h, expected fuse=%0b kind=%0d dest=%0d imm=%h",
                     e.tag, fuse, kind, dest, imm, e.fuse, e.kind, e.dest, e.imm);
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      nofuse(32'd0, 32'd0, "R11 idle zero words");

      // R1
      apply(lui(5'd5, 20'h12345), addi(5'd5, 5'd5, 12'h7FF), 1'b1, 4'd1, 5'd5,
            32'h12345000 + 32'h7FF, "R1 positive low part");
      apply(lui(5'd5, 20'h12345), addi(5'd5, 5'd5, 12'hFFF), 1'b1, 4'd1, 5'd5,
            32'h12345000 - 32'd1, "R1 negative low part");
      nofuse(lui(5'd5, 20'h12345), addi(5'd5, 5'd6, 12'h001), "R1 wrong addi source");
      // R2
      apply(add(5'd7, 5'd1, 5'd2), ld(5'd7, 5'd7, 12'd0), 1'b1, 4'd2, 5'd7, 32'd0, "R2 indexed load");
      nofuse(add(5'd7, 5'd1, 5'd2), ld(5'd7, 5'd7, 12'd8), "R2 nonzero offset");
      // R3
      apply(slli(5'd9, 5'd3, 6'd2), add(5'd9, 5'd9, 5'd4), 1'b1, 4'd3, 5'd9, 32'd2, "R3 shift 2");
      apply(slli(5'd9, 5'd3, 6'd3), add(5'd9, 5'd9, 5'd4), 1'b1, 4'd3, 5'd9, 32'd3, "R3 shift 3");
      nofuse(slli(5'd9, 5'd3, 6'd4), add(5'd9, 5'd9, 5'd4), "R3 shift 4");
      // R4
      apply(auipc(5'd6, 20'h00010), jalr(5'd1, 5'd6, 12'hFF0), 1'b1, 4'd4, 5'd1,
            32'h00010000 - 32'd16, "R4 pc call");
      nofuse(auipc(5'd6, 20'h00010), jalr(5'd0, 5'd6, 12'hFF0), "R4 link x0");
      // R5
      apply(md(3'b011, 5'd10, 5'd11, 5'd12), md(3'b000, 5'd13, 5'd11, 5'd12), 1'b1, 4'd5, 5'd13,
            32'd0, "R5 mulhu+mul");
      nofuse(md(3'b001, 5'd11, 5'd11, 5'd12), md(3'b000, 5'd13, 5'd11, 5'd12), "R5 head clobbers rs1");
      nofuse(md(3'b001, 5'd12, 5'd11, 5'd12), md(3'b000, 5'd13, 5'd11, 5'd12), "R5 head clobbers rs2");
      // R6
      apply(md(3'b100, 5'd14, 5'd1, 5'd2), md(3'b110, 5'd15, 5'd1, 5'd2), 1'b1, 4'd6, 5'd15,
            32'd0, "R6 div+rem");
      apply(md(3'b101, 5'd14, 5'd1, 5'd2), md(3'b111, 5'd15, 5'd1, 5'd2), 1'b1, 4'd6, 5'd15,
            32'd0, "R6 divu+remu");
      nofuse(md(3'b100, 5'd14, 5'd1, 5'd2), md(3'b111, 5'd15, 5'd1, 5'd2), "R6 mixed signedness");
      nofuse(md(3'b100, 5'd14, 5'd1, 5'd2), md(3'b110, 5'd15, 5'd2, 5'd1), "R6 swapped sources");
      // R7
      apply(slli(5'd8, 5'd2, 6'd32), srli(5'd8, 5'd8, 6'd30), 1'b1, 4'd7, 5'd8, 32'd30, "R7 k=30");
      apply(slli(5'd8, 5'd2, 6'd32), srli(5'd8, 5'd8, 6'd32), 1'b1, 4'd7, 5'd8, 32'd32, "R7 k=32");
      nofuse(slli(5'd8, 5'd2, 6'd32), srli(5'd8, 5'd8, 6'd28), "R7 k=28");
      // R8
      apply(ld(5'd3, 5'd2, 12'd16), ld(5'd4, 5'd2, 12'd24), 1'b1, 4'd8, 5'd3, 32'd16, "R8 load pair");
      apply(ld(5'd3, 5'd2, 12'hFF8), ld(5'd4, 5'd2, 12'd0), 1'b1, 4'd8, 5'd3, 32'hFFFFFFF8,
            "R8 negative offset pair");
      nofuse(ld(5'd3, 5'd2, 12'd16), ld(5'd4, 5'd2, 12'd32), "R8 stride 16");
      nofuse(ld(5'd2, 5'd2, 12'd16), ld(5'd4, 5'd2, 12'd24), "R8 base overwritten");
      // R9
      apply(sd(5'd3, 5'd2, 12'hFE0), sd(5'd4, 5'd2, 12'hFE8), 1'b1, 4'd9, 5'd0, 32'hFFFFFFE0,
            "R9 store pair");
      nofuse(sd(5'd3, 5'd2, 12'd0), sd(5'd4, 5'd5, 12'd8), "R9 different base");
      // R10
      apply(lui(5'd5, 20'h80000), ld(5'd5, 5'd5, 12'hFFC), 1'b1, 4'd10, 5'd5,
            32'h80000000 - 32'd4, "R10 absolute load");
      apply(auipc(5'd5, 20'h00001), ld(5'd5, 5'd5, 12'd8), 1'b1, 4'd11, 5'd5, 32'h00001008,
            "R10 pc-relative load");
      nofuse(lui(5'd5, 20'h00001), ld(5'd6, 5'd5, 12'd8), "R10 different load dest");
      // R11 / R12: unrelated pair
      nofuse(add(5'd1, 5'd2, 5'd3), sd(5'd1, 5'd2, 12'd0), "R11 unrelated pair");
      apply(lui(5'd31, 20'hFFFFF), addi(5'd31, 5'd31, 12'h800), 1'b1, 4'd1, 5'd31,
            32'hFFFFF000 - 32'd2048, "R12 single kind on wide constant");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule